// File: doc/BRIEF.md
# Tightly Coupled Memory Port Arbiter

This block sits in front of one 64-bit tightly coupled memory and decides, every cycle, which of two requesters may issue a command to it: a processor port and a DMA port. Each memory in the system has its own instance. Each port carries a valid/ready request with address, write flag, 64-bit write data and eight byte strobes. The processor wins any cycle in which both ports contend for the same bank.

A starvation guard stops the DMA from waiting for ever. A per-bank counter tracks consecutive processor grants made while the DMA is waiting on that bank. When it reaches the limit (15 by default), the next contested slot goes to the DMA. Under full processor load the DMA therefore receives one grant in every 16.

An elaboration option splits the memory into two banks. Address bit 3 picks the bank, so consecutive 64-bit words alternate between banks. The two ports are then granted together whenever they address different banks. Grants are combinational: a lone requester is accepted in the cycle it raises valid.

Top module: `tcm_port_arbiter`

## Requirements
- R1: A granted request is forwarded unchanged on its bank lane: address, write flag, all 64 write-data bits and all 8 byte strobes. The lane's source flag is 0 for the processor and 1 for the DMA.
- R2: When both ports request the same bank and the starvation count of that bank is below the limit, the processor is granted and the DMA is held.
- R3: After 15 (STARVE_LIMIT) consecutive processor grants on a bank while the DMA waits on that bank, the DMA is granted in the next cycle it still requests that bank. Under saturation, every 16 consecutive cycles contain at least one DMA grant.
- R4: A bank's starvation count clears when the DMA is granted on it, or when the DMA stops requesting that bank for a cycle. The next wait then starts from zero.
- R5: A port requesting a bank that the other port does not request is granted in the same cycle, with no added latency.
- R6: A ready is raised only with its valid. Each bank lane carries at most one command per cycle. The number of active lanes equals the number of readies raised.
- R7: In two-bank mode (DUAL_BANK=1), address bit 3 selects lane 0 or lane 1, and both ports are granted in the same cycle when their bit 3 differs. In single-bank mode only lane 0 exists, and the two ports are never granted together.
- R8: Reset (rstN low) clears every starvation count, so the first contention after reset again gives the processor 15 grants before the DMA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Processor request valid |
| cpuReady | output | 1 | Processor request accepted this cycle |
| cpuAddr | input | ADDR_W | Processor byte address |
| cpuWrite | input | 1 | Processor write flag |
| cpuWdata | input | DATA_W | Processor write data |
| cpuStrb | input | DATA_W/8 | Processor byte strobes |
| dmaValid | input | 1 | DMA request valid |
| dmaReady | output | 1 | DMA request accepted this cycle |
| dmaAddr | input | ADDR_W | DMA byte address |
| dmaWrite | input | 1 | DMA write flag |
| dmaWdata | input | DATA_W | DMA write data |
| dmaStrb | input | DATA_W/8 | DMA byte strobes |
| memValid | output | NUM_BANKS | Command valid per bank lane |
| memSrc | output | NUM_BANKS | Lane source: 0 processor, 1 DMA |
| memAddr | output | NUM_BANKS*ADDR_W | Lane address |
| memWrite | output | NUM_BANKS | Lane write flag |
| memWdata | output | NUM_BANKS*DATA_W | Lane write data |
| memStrb | output | NUM_BANKS*DATA_W/8 | Lane byte strobes |

## Verification
The hardest state to reach from the ports is the slot where a bank's starvation count sits exactly at its limit. It needs fifteen unbroken cycles of same-bank contention, with no gap in the DMA request and no reset. The stimulus holds both ports on the same bank for long runs and checks the forced DMA slot at cycles 16, 32 and 48. It then breaks a partial run with a one-cycle DMA drop, and again with a reset, to show that the count restarts. Two-bank concurrency is reached by giving the two ports opposite values of address bit 3, and a long random mix with a busy processor covers everything in between.

// File: rtl/tcm_arb_pkg.sv
package tcm_arb_pkg;
  // Per-lane grant strobes handed from control to datapath
  typedef struct packed {
    logic cpuSel;
    logic dmaSel;
  } laneSel_t;
endpackage

// File: rtl/tcm_arb_starve.sv
// Starvation counter for one bank lane: counts CPU wins while the DMA waits.
module tcm_arb_starve #(
  parameter int STARVE_LIMIT = 15
) (
  input  logic clk,
  input  logic rstN,
  input  logic dmaHit,
  input  logic cpuWin,
  input  logic dmaWin,
  output logic atLimit
);
  localparam int CNT_W = $clog2(STARVE_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(STARVE_LIMIT);

  logic [CNT_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (!dmaHit || dmaWin) begin
      waitCnt <= '0;
    end else if (cpuWin && waitCnt != LIMIT_V) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end

  assign atLimit = (waitCnt == LIMIT_V);
endmodule

// File: rtl/tcm_arb_ctrl.sv
// Grant decision per bank lane: fixed CPU priority with a starvation override.
module tcm_arb_ctrl
  import tcm_arb_pkg::*;
#(
  parameter int NUM_BANKS    = 2,
  parameter int STARVE_LIMIT = 15
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cpuValid,
  input  logic                           cpuBank,
  input  logic                           dmaValid,
  input  logic                           dmaBank,
  output laneSel_t [NUM_BANKS-1:0]       laneSel,
  output logic                           cpuGrant,
  output logic                           dmaGrant
);
  logic [NUM_BANKS-1:0] cpuWinVec;
  logic [NUM_BANKS-1:0] dmaWinVec;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lane
    logic cpuHit;
    logic dmaHit;
    logic atLimit;

    assign cpuHit = cpuValid && (cpuBank == 1'(b));
    assign dmaHit = dmaValid && (dmaBank == 1'(b));

    assign dmaWinVec[b] = dmaHit && (!cpuHit || atLimit);
    assign cpuWinVec[b] = cpuHit && !dmaWinVec[b];

    tcm_arb_starve #(.STARVE_LIMIT(STARVE_LIMIT)) u_starve (
      .clk    (clk),
      .rstN   (rstN),
      .dmaHit (dmaHit),
      .cpuWin (cpuWinVec[b]),
      .dmaWin (dmaWinVec[b]),
      .atLimit(atLimit)
    );

    assign laneSel[b].cpuSel = cpuWinVec[b];
    assign laneSel[b].dmaSel = dmaWinVec[b];
  end

  assign cpuGrant = |cpuWinVec;
  assign dmaGrant = |dmaWinVec;
endmodule

// File: rtl/tcm_arb_dpath.sv
// Command steering: each lane carries the fields of the port selected for it.
module tcm_arb_dpath
  import tcm_arb_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 64
) (
  input  laneSel_t [NUM_BANKS-1:0]        laneSel,
  input  logic [ADDR_W-1:0]               cpuAddr,
  input  logic                            cpuWrite,
  input  logic [DATA_W-1:0]               cpuWdata,
  input  logic [DATA_W/8-1:0]             cpuStrb,
  input  logic [ADDR_W-1:0]               dmaAddr,
  input  logic                            dmaWrite,
  input  logic [DATA_W-1:0]               dmaWdata,
  input  logic [DATA_W/8-1:0]             dmaStrb,
  output logic [NUM_BANKS-1:0]            memValid,
  output logic [NUM_BANKS-1:0]            memSrc,
  output logic [NUM_BANKS*ADDR_W-1:0]     memAddr,
  output logic [NUM_BANKS-1:0]            memWrite,
  output logic [NUM_BANKS*DATA_W-1:0]     memWdata,
  output logic [NUM_BANKS*DATA_W/8-1:0]   memStrb
);
  localparam int STRB_W = DATA_W / 8;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lane
    logic pickDma;
    assign pickDma = laneSel[b].dmaSel;

    assign memValid[b] = laneSel[b].cpuSel | laneSel[b].dmaSel;
    assign memSrc[b]   = pickDma;
    assign memWrite[b] = pickDma ? dmaWrite : cpuWrite;
    assign memAddr[b*ADDR_W +: ADDR_W]  = pickDma ? dmaAddr  : cpuAddr;
    assign memWdata[b*DATA_W +: DATA_W] = pickDma ? dmaWdata : cpuWdata;
    assign memStrb[b*STRB_W +: STRB_W]  = pickDma ? dmaStrb  : cpuStrb;
  end
endmodule

// File: rtl/tcm_port_arbiter.sv
// Two-port arbiter for one tightly coupled memory, optional two-bank interleave.
module tcm_port_arbiter
  import tcm_arb_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 64,
  parameter int STARVE_LIMIT = 15,
  parameter bit DUAL_BANK    = 1'b1,
  localparam int NUM_BANKS   = DUAL_BANK ? 2 : 1,
  localparam int STRB_W      = DATA_W / 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cpuValid,
  output logic                          cpuReady,
  input  logic [ADDR_W-1:0]             cpuAddr,
  input  logic                          cpuWrite,
  input  logic [DATA_W-1:0]             cpuWdata,
  input  logic [STRB_W-1:0]             cpuStrb,
  input  logic                          dmaValid,
  output logic                          dmaReady,
  input  logic [ADDR_W-1:0]             dmaAddr,
  input  logic                          dmaWrite,
  input  logic [DATA_W-1:0]             dmaWdata,
  input  logic [STRB_W-1:0]             dmaStrb,
  output logic [NUM_BANKS-1:0]          memValid,
  output logic [NUM_BANKS-1:0]          memSrc,
  output logic [NUM_BANKS*ADDR_W-1:0]   memAddr,
  output logic [NUM_BANKS-1:0]          memWrite,
  output logic [NUM_BANKS*DATA_W-1:0]   memWdata,
  output logic [NUM_BANKS*STRB_W-1:0]   memStrb
);
  localparam int BANK_LSB = $clog2(STRB_W);

  laneSel_t [NUM_BANKS-1:0] laneSel;
  logic cpuBank;
  logic dmaBank;

  if (DUAL_BANK) begin : g_bank_dual
    assign cpuBank = cpuAddr[BANK_LSB];
    assign dmaBank = dmaAddr[BANK_LSB];
  end else begin : g_bank_single
    assign cpuBank = 1'b0;
    assign dmaBank = 1'b0;
  end

  tcm_arb_ctrl #(
    .NUM_BANKS   (NUM_BANKS),
    .STARVE_LIMIT(STARVE_LIMIT)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cpuValid(cpuValid),
    .cpuBank (cpuBank),
    .dmaValid(dmaValid),
    .dmaBank (dmaBank),
    .laneSel (laneSel),
    .cpuGrant(cpuReady),
    .dmaGrant(dmaReady)
  );

  tcm_arb_dpath #(
    .NUM_BANKS(NUM_BANKS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
  ) u_dpath (
    .laneSel (laneSel),
    .cpuAddr (cpuAddr),
    .cpuWrite(cpuWrite),
    .cpuWdata(cpuWdata),
    .cpuStrb (cpuStrb),
    .dmaAddr (dmaAddr),
    .dmaWrite(dmaWrite),
    .dmaWdata(dmaWdata),
    .dmaStrb (dmaStrb),
    .memValid(memValid),
    .memSrc  (memSrc),
    .memAddr (memAddr),
    .memWrite(memWrite),
    .memWdata(memWdata),
    .memStrb (memStrb)
  );
endmodule

// File: rtl/tcm_port_arbiter_chk.sv
// Protocol and fairness properties, attached to every arbiter instance.
module tcm_port_arbiter_chk #(
  parameter int NUM_BANKS    = 2,
  parameter int STARVE_LIMIT = 15
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cpuValid,
  input logic                 cpuReady,
  input logic                 cpuBank,
  input logic                 dmaValid,
  input logic                 dmaReady,
  input logic                 dmaBank,
  input logic [NUM_BANKS-1:0] memValid
);
  localparam bit DUAL = (NUM_BANKS > 1);

  logic sameBank;
  logic prevDmaBank;
  int unsigned lostCnt;
  int unsigned effCnt;

  assign sameBank = !DUAL || (cpuBank == dmaBank);
  assign effCnt   = (DUAL && dmaBank != prevDmaBank) ? 0 : lostCnt;

  // Independent count of cycles the DMA lost to the CPU on its current bank
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lostCnt     <= 0;
      prevDmaBank <= 1'b0;
    end else begin
      prevDmaBank <= dmaBank;
      if (!dmaValid || dmaReady) lostCnt <= 0;
      else if (cpuReady && sameBank) lostCnt <= effCnt + 1;
      else lostCnt <= effCnt;
    end
  end

  assert_cpu_priority_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && dmaValid && sameBank && effCnt < STARVE_LIMIT) |-> (cpuReady && !dmaReady));

  assert_starve_slot_R3: assert property (@(posedge clk) disable iff (!rstN)
    (dmaValid && effCnt >= STARVE_LIMIT) |-> dmaReady);

  assert_lone_cpu_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && !(dmaValid && sameBank)) |-> cpuReady);

  assert_lone_dma_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dmaValid && !(cpuValid && sameBank)) |-> dmaReady);

  assert_ready_needs_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReady |-> cpuValid) and (dmaReady |-> dmaValid));

  assert_lane_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    $countones(memValid) == (32'(cpuReady) + 32'(dmaReady)));

  assert_dual_grant_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReady && dmaReady) |-> (DUAL && !sameBank));
endmodule

bind tcm_port_arbiter tcm_port_arbiter_chk #(
  .NUM_BANKS   (NUM_BANKS),
  .STARVE_LIMIT(STARVE_LIMIT)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cpuValid(cpuValid),
  .cpuReady(cpuReady),
  .cpuBank (cpuBank),
  .dmaValid(dmaValid),
  .dmaReady(dmaReady),
  .dmaBank (dmaBank),
  .memValid(memValid)
);

// File: tb/tcm_port_arbiter_test.sv
module tcm_port_arbiter_test;
  localparam int PERIOD = 10;
  localparam int LIMIT  = 15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic        cpuValid = 0, cpuWrite = 0, dmaValid = 0, dmaWrite = 0;
  logic [15:0] cpuAddr = 0, dmaAddr = 0;
  logic [63:0] cpuWdata = 0, dmaWdata = 0;
  logic [7:0]  cpuStrb = 0, dmaStrb = 0;

  logic        dCpuReady, dDmaReady, sCpuReady, sDmaReady;
  logic [1:0]  dMemValid, dMemSrc, dMemWrite;
  logic [31:0] dMemAddr;
  logic [127:0] dMemWdata;
  logic [15:0] dMemStrb;
  logic [0:0]  sMemValid, sMemSrc, sMemWrite;
  logic [15:0] sMemAddr;
  logic [63:0] sMemWdata;
  logic [7:0]  sMemStrb;

  tcm_port_arbiter #(.DUAL_BANK(1'b1)) uut (
    .clk(clk), .rstN(rstN),
    .cpuValid(cpuValid), .cpuReady(dCpuReady), .cpuAddr(cpuAddr), .cpuWrite(cpuWrite),
    .cpuWdata(cpuWdata), .cpuStrb(cpuStrb),
    .dmaValid(dmaValid), .dmaReady(dDmaReady), .dmaAddr(dmaAddr), .dmaWrite(dmaWrite),
    .dmaWdata(dmaWdata), .dmaStrb(dmaStrb),
    .memValid(dMemValid), .memSrc(dMemSrc), .memAddr(dMemAddr), .memWrite(dMemWrite),
    .memWdata(dMemWdata), .memStrb(dMemStrb));

  tcm_port_arbiter #(.DUAL_BANK(1'b0)) uutOne (
    .clk(clk), .rstN(rstN),
    .cpuValid(cpuValid), .cpuReady(sCpuReady), .cpuAddr(cpuAddr), .cpuWrite(cpuWrite),
    .cpuWdata(cpuWdata), .cpuStrb(cpuStrb),
    .dmaValid(dmaValid), .dmaReady(sDmaReady), .dmaAddr(dmaAddr), .dmaWrite(dmaWrite),
    .dmaWdata(dmaWdata), .dmaStrb(dmaStrb),
    .memValid(sMemValid), .memSrc(sMemSrc), .memAddr(sMemAddr), .memWrite(sMemWrite),
    .memWdata(sMemWdata), .memStrb(sMemStrb));

  int vectors = 0;
  int fails = 0;
  int waitD[2];   // reference starvation counts, two-bank instance
  int waitS;      // reference starvation count, single-bank instance
  bit dmaLog[$];  // DMA grant history of uut during saturation

  task automatic expectVal(string tag, string what, logic [127:0] act, logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Reference: who should win lane b given the reference count
  function automatic void refLane(int nb, int b, int cnt, output bit cw, output bit dw);
    bit ch, dh;
    ch = cpuValid && (nb == 1 || int'(cpuAddr[3]) == b);
    dh = dmaValid && (nb == 1 || int'(dmaAddr[3]) == b);
    dw = dh && (!ch || cnt >= LIMIT);
    cw = ch && !dw;
  endfunction

  task automatic checkNow(string tag);
    bit cw, dw, anyC, anyD;
    // two-bank instance
    anyC = 0; anyD = 0;
    for (int b = 0; b < 2; b++) begin
      refLane(2, b, waitD[b], cw, dw);
      anyC |= cw; anyD |= dw;
      expectVal(tag, $sformatf("uut lane%0d valid", b), 128'(dMemValid[b]), 128'(cw | dw));
      if (cw | dw) begin
        expectVal("R1", $sformatf("uut lane%0d src", b), 128'(dMemSrc[b]), 128'(dw));
        expectVal("R1", $sformatf("uut lane%0d addr", b), 128'(dMemAddr[b*16 +: 16]),
                  128'(dw ? dmaAddr : cpuAddr));
        expectVal("R1", $sformatf("uut lane%0d write", b), 128'(dMemWrite[b]),
                  128'(dw ? dmaWrite : cpuWrite));
        expectVal("R1", $sformatf("uut lane%0d data", b), 128'(dMemWdata[b*64 +: 64]),
                  128'(dw ? dmaWdata : cpuWdata));
        expectVal("R1", $sformatf("uut lane%0d strb", b), 128'(dMemStrb[b*8 +: 8]),
                  128'(dw ? dmaStrb : cpuStrb));
      end
    end
    expectVal(tag, "uut cpuReady", 128'(dCpuReady), 128'(anyC));
    expectVal(tag, "uut dmaReady", 128'(dDmaReady), 128'(anyD));
    // single-bank instance
    refLane(1, 0, waitS, cw, dw);
    expectVal(tag, "uutOne cpuReady", 128'(sCpuReady), 128'(cw));
    expectVal(tag, "uutOne dmaReady", 128'(sDmaReady), 128'(dw));
    expectVal(tag, "uutOne lane valid", 128'(sMemValid), 128'(cw | dw));
    if (cw | dw) begin
      expectVal("R1", "uutOne src", 128'(sMemSrc), 128'(dw));
      expectVal("R1", "uutOne data", 128'(sMemWdata), 128'(dw ? dmaWdata : cpuWdata));
      expectVal("R1", "uutOne addr", 128'(sMemAddr), 128'(dw ? dmaAddr : cpuAddr));
    end
  endtask

  function automatic int nextCnt(int nb, int b, int cnt);
    bit cw, dw, dh;
    refLane(nb, b, cnt, cw, dw);
    dh = dmaValid && (nb == 1 || int'(dmaAddr[3]) == b);
    if (!dh || dw) return 0;
    return cw ? cnt + 1 : cnt;
  endfunction

  // Inputs are set at a falling edge; compare 1 time unit later, update at the rising edge
  task automatic step(string tag);
    #1;
    checkNow(tag);
    dmaLog.push_back(dDmaReady);
    @(posedge clk);
    for (int b = 0; b < 2; b++) waitD[b] = nextCnt(2, b, waitD[b]);
    waitS = nextCnt(1, 0, waitS);
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    waitD[0] = 0; waitD[1] = 0; waitS = 0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic setCpu(bit v, logic [15:0] a);
    cpuValid = v; cpuAddr = a; cpuWrite = a[4];
    cpuWdata = {a, ~a, a ^ 16'h5a5a, 16'hc0de}; cpuStrb = a[7:0] | 8'h01;
  endtask

  task automatic setDma(bit v, logic [15:0] a);
    dmaValid = v; dmaAddr = a; dmaWrite = ~a[4];
    dmaWdata = {16'hd3a0, a, ~a, a + 16'h1111}; dmaStrb = ~a[7:0] | 8'h80;
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    waitD[0] = 0; waitD[1] = 0; waitS = 0;
    @(negedge clk);
    doReset();

    // R6: idle after reset, nothing issued
    setCpu(0, 16'h0); setDma(0, 16'h0);
    step("R6");
    expectVal("R6", "uut idle lanes", 128'(dMemValid), 128'(0));

    // R5: lone requesters, each in both banks
    setCpu(1, 16'h0010); step("R5");
    setCpu(1, 16'h0018); step("R5");
    setCpu(0, 16'h0); setDma(1, 16'h0100); step("R5");
    setDma(1, 16'h0108); step("R5");
    setDma(0, 16'h0);

    // R7: different banks granted together in two-bank mode only
    setCpu(1, 16'h0020); setDma(1, 16'h0028); step("R7");
    expectVal("R7", "uut both ready", 128'({dCpuReady, dDmaReady}), 128'(2'b11));
    setCpu(1, 16'h0038); setDma(1, 16'h0030); step("R7");
    setCpu(0, 16'h0); setDma(0, 16'h0); step("R7");

    // R2/R3: saturation on the same bank for 48 cycles
    dmaLog.delete();
    for (int i = 0; i < 48; i++) begin
      setCpu(1, 16'h0040 + 16'(i * 16)); setDma(1, 16'h0200);
      step(i == 0 ? "R2" : "R3");
    end
    begin
      int total = 0;
      foreach (dmaLog[k]) total += int'(dmaLog[k]);
      expectVal("R3", "DMA grants in 48 saturated cycles", 128'(total), 128'(3));
      for (int s = 0; s + 16 <= dmaLog.size(); s++) begin
        int inWin = 0;
        for (int k = s; k < s + 16; k++) inWin += int'(dmaLog[k]);
        expectVal("R3", $sformatf("DMA grant in window %0d", s), 128'(inWin >= 1), 128'(1));
      end
      expectVal("R3", "16th cycle goes to DMA", 128'(dmaLog[15]), 128'(1));
    end

    // R4: partial wait, DMA drops for one cycle, count restarts
    for (int i = 0; i < 10; i++) begin
      setCpu(1, 16'h0400); setDma(1, 16'h0500); step("R4");
    end
    setDma(0, 16'h0500); step("R4");
    dmaLog.delete();
    for (int i = 0; i < 16; i++) begin
      setCpu(1, 16'h0400); setDma(1, 16'h0500); step("R4");
    end
    expectVal("R4", "no early DMA grant after drop", 128'(dmaLog[9]), 128'(0));
    expectVal("R4", "DMA grant at slot 16 after drop", 128'(dmaLog[15]), 128'(1));

    // R8: reset during a wait clears the count
    for (int i = 0; i < 12; i++) begin
      setCpu(1, 16'h0600); setDma(1, 16'h0600); step("R8");
    end
    doReset();
    dmaLog.delete();
    for (int i = 0; i < 16; i++) begin
      setCpu(1, 16'h0600); setDma(1, 16'h0600); step("R8");
    end
    expectVal("R8", "DMA held after reset", 128'(dmaLog[5]), 128'(0));
    expectVal("R8", "DMA slot 16 after reset", 128'(dmaLog[15]), 128'(1));
    setCpu(0, 16'h0); setDma(0, 16'h0); step("R8");

    // Mixed traffic with a busy processor
    for (int i = 0; i < 600; i++) begin
      setCpu(($urandom % 10) != 0, 16'($urandom));
      setDma(($urandom % 4) != 0, 16'($urandom % 4 == 0 ? $urandom : 32'h0700));
      step("R2");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule